// File: doc/BRIEF.md
# Exception Entry Stack Sequencer

This block performs the memory and register work that follows the acceptance of a user interrupt. It receives a one-cycle start pulse together with a snapshot of the processor state: the program counter of the interrupted instruction, a 2-bit instruction class, the status word, the system stack pointer and the accepted interrupt level. It then makes two 32-bit stack pushes through a valid/ready write port and finally loads the accepted level into the interrupt level mask.

The status word is pushed first, at the stack pointer minus 4. The return address is pushed second, at the stack pointer minus 8. The return address is the program counter plus the length of the interrupted instruction, which the instruction class selects. The updated stack pointer and level mask are registered outputs that the surrounding core adopts. Fetching the handler vector and the return sequence are handled elsewhere.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), sp_out is 0, lvl_mask is all ones, and wr_valid, busy and done are 0.
- R2: When iclass is 2 (32-bit immediate load), the pushed return address is pc_in + 6.
- R3: When iclass is 1 (20-bit immediate load or a coprocessor operate, load, store or save), the pushed return address is pc_in + 4.
- R4: When iclass is 0 or 3, the pushed return address is pc_in + 2.
- R5: The first write request appears in the cycle after start. Its address is sp_in - 4 and its data is status_in, and sp_out equals sp_in - 4.
- R6: After the first write is accepted, the second write has address sp_in - 8 and carries the return address. sp_out equals sp_in - 8 from then on. Arithmetic wraps modulo 2^32.
- R7: A write request stays valid, with unchanged address and data, in every cycle until wr_ready is high at a clock edge. No other progress is made meanwhile.
- R8: At the edge that accepts the second write, lvl_mask takes the captured level. done is high for exactly the following cycle, and busy is 0 in that cycle.
- R9: A start pulse while busy is 1 is ignored. After the current sequence completes, no further write is requested, and lvl_mask keeps the level of the first sequence.
- R10: pc_in, iclass, status_in, sp_in and level_in are sampled only in the start cycle. Later changes to them do not alter the writes or the final level mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to run the entry sequence |
| pc_in | input | XLEN | Address of the interrupted instruction |
| iclass | input | 2 | Instruction length class: 0 other, 1 medium, 2 long |
| status_in | input | XLEN | Status word to push |
| sp_in | input | XLEN | Current system stack pointer |
| level_in | input | LVL_W | Level of the accepted request |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | XLEN | Write word address |
| wr_data | output | XLEN | Write word data |
| wr_ready | input | 1 | Write accepted at this edge when high with wr_valid |
| sp_out | output | XLEN | Updated stack pointer |
| lvl_mask | output | LVL_W | Interrupt level mask |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch every cycle for write requests that stay stable during a stall, for the 4-byte stack-pointer step at each accepted push, for a done pulse that lasts a single cycle and follows an accepted write, and for a start in idle being followed by a request. The exact return-address offsets, the sampling of inputs only at start, and the rejection of a start pulse during a sequence depend on data values chosen by the scenario. The bench checks these against its own expected values while varying stall patterns on wr_ready.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN  = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [1:0]       iclass,
  input  logic [XLEN-1:0]  status_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [LVL_W-1:0] level_in,
  output logic             wr_valid,
  output logic [XLEN-1:0]  wr_addr,
  output logic [XLEN-1:0]  wr_data,
  input  logic             wr_ready,
  output logic [XLEN-1:0]  sp_out,
  output logic [LVL_W-1:0] lvl_mask,
  output logic             busy,
  output logic             done
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  typedef enum logic [1:0] {S_IDLE, S_PS, S_RA} st_t;

  st_t              st;
  logic [XLEN-1:0]  sp_q, ps_q, ra_q, step;
  logic [LVL_W-1:0] lvl_q, ilm_q;
  logic             done_q;

  always_comb begin
    case (iclass)
      2'd2:    step = XLEN'(6);
      2'd1:    step = XLEN'(4);
      default: step = XLEN'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sp_q   <= '0;
      ps_q   <= '0;
      ra_q   <= '0;
      lvl_q  <= '0;
      ilm_q  <= '1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sp_q  <= sp_in - WORD;
          ps_q  <= status_in;
          ra_q  <= pc_in + step;
          lvl_q <= level_in;
          st    <= S_PS;
        end
        S_PS: if (wr_ready) begin
          sp_q <= sp_q - WORD;
          st   <= S_RA;
        end
        S_RA: if (wr_ready) begin
          ilm_q  <= lvl_q;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_valid = (st != S_IDLE);
  assign busy     = wr_valid;
  assign wr_addr  = sp_q;
  assign wr_data  = (st == S_RA) ? ra_q : ps_q;
  assign sp_out   = sp_q;
  assign lvl_mask = ilm_q;
  assign done     = done_q;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN  = 32,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wr_valid,
  input logic [XLEN-1:0]  wr_addr,
  input logic [XLEN-1:0]  wr_data,
  input logic             wr_ready,
  input logic [XLEN-1:0]  sp_out,
  input logic [LVL_W-1:0] lvl_mask,
  input logic             busy,
  input logic             done
);
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(sp_out)));

  assert_sp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (done ? $stable(sp_out) : (sp_out == $past(sp_out) - XLEN'(4))));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_valid && wr_ready) && !busy && !wr_valid));

  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$rose(done)) |-> $stable(lvl_mask) or $past(wr_valid && wr_ready));

  assert_start_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (wr_valid && busy));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
  .sp_out(sp_out), .lvl_mask(lvl_mask), .busy(busy), .done(done)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk = 0, rst_n = 0, start = 0, wr_ready = 0;
  logic [31:0] pc_in = 0, status_in = 0, sp_in = 0;
  logic [1:0]  iclass = 0;
  logic [4:0]  level_in = 0;
  logic        wr_valid, busy, done;
  logic [31:0] wr_addr, wr_data, sp_out;
  logic [4:0]  lvl_mask;
  int n_chk = 0, n_fail = 0, cycles = 0;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .iclass(iclass),
    .status_in(status_in), .sp_in(sp_in), .level_in(level_in),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .sp_out(sp_out), .lvl_mask(lvl_mask), .busy(busy), .done(done));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ret(input logic [31:0] pc, input logic [1:0] c);
    case (c)
      2'd2:    return pc + 32'd6;
      2'd1:    return pc + 32'd4;
      default: return pc + 32'd2;
    endcase
  endfunction

  function automatic string ret_req(input logic [1:0] c);
    return (c == 2'd2) ? "R2" : (c == 2'd1) ? "R3" : "R4";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_seq(input logic [31:0] pc, input logic [1:0] c, input logic [31:0] st,
                         input logic [31:0] sp, input logic [4:0] lvl, input bit stall, input bit poke);
    int idx = 0;
    bit stalled = 0, poked = 0;
    logic [31:0] ea, ed;
    @(negedge clk);
    start = 1; pc_in = pc; iclass = c; status_in = st; sp_in = sp; level_in = lvl;
    @(negedge clk);
    start = 0;
    pc_in = $urandom; iclass = 2'($urandom); status_in = $urandom; sp_in = $urandom; level_in = 5'($urandom);
    while (idx < 2) begin
      ea = (idx == 0) ? sp - 32'd4 : sp - 32'd8;
      ed = (idx == 0) ? st : exp_ret(pc, c);
      chk(wr_valid === 1'b1, stalled ? "R7 valid" : "R5 valid", 32'(wr_valid), 1);
      chk(wr_addr === ea, stalled ? "R7 addr" : (idx == 0 ? "R5 addr" : "R6 addr"), wr_addr, ea);
      chk(wr_data === ed, stalled ? "R7 data" : (idx == 0 ? "R5 data" : {ret_req(c), " data R10"}), wr_data, ed);
      chk(sp_out === ea, idx == 0 ? "R5 sp" : "R6 sp", sp_out, ea);
      wr_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      if (poke && idx == 1 && !poked) begin
        start = 1; pc_in = $urandom; sp_in = $urandom; level_in = ~lvl; poked = 1;
      end
      @(negedge clk);
      start = 0;
      stalled = !wr_ready;
      if (wr_ready) idx++;
      wr_ready = 0;
    end
    chk(done === 1'b1, "R8 done", 32'(done), 1);
    chk(lvl_mask === lvl, "R8 mask R10", 32'(lvl_mask), 32'(lvl));
    chk(busy === 1'b0, "R8 busy", 32'(busy), 0);
    chk(sp_out === sp - 32'd8, "R6 final sp", sp_out, sp - 32'd8);
    @(negedge clk);
    chk(done === 1'b0, "R8 single pulse", 32'(done), 0);
    chk(wr_valid === 1'b0, poke ? "R9 no restart" : "R8 idle", 32'(wr_valid), 0);
    chk(lvl_mask === lvl, poke ? "R9 mask kept" : "R8 mask kept", 32'(lvl_mask), 32'(lvl));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(sp_out === 32'd0, "R1 sp", sp_out, 0);
    chk(lvl_mask === 5'h1F, "R1 mask", 32'(lvl_mask), 32'h1F);
    chk({wr_valid, busy, done} === 3'b000, "R1 ctl", 32'({wr_valid, busy, done}), 0);
    rst_n = 1;
    run_seq(32'h0000_1000, 2'd2, 32'hDEAD_BEEF, 32'h0000_8000, 5'd3, 0, 0);
    run_seq(32'h0000_2002, 2'd1, 32'h1234_5678, 32'h0000_4000, 5'd17, 1, 0);
    run_seq(32'h0000_3004, 2'd0, 32'hA5A5_0F0F, 32'h0000_0100, 5'd0, 1, 1);
    run_seq(32'h0000_4006, 2'd3, 32'h0, 32'h0000_0200, 5'd31, 0, 0);
    run_seq(32'hFFFF_FFFC, 2'd2, 32'hFFFF_FFFF, 32'h0000_0004, 5'd8, 1, 0);
    for (int i = 0; i < 30; i++)
      run_seq($urandom & 32'hFFFF_FFFE, 2'($urandom), $urandom, $urandom & 32'hFFFF_FFFC,
              5'($urandom), 1, (i % 4) == 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule